// File: doc/BRIEF.md
# Bootstrap Memory Copy Engine

This block keeps a small bootstrap program in a retained on-chip memory and copies it into a processor's instruction memory. A host loads the retained memory one dword at a time over a simple 32-bit register bus. Over the same bus it programs three values: where to read in the retained memory, where to write in instruction memory, and how many dwords to move. It then starts the copy and polls until the copy has finished.

The engine can also be armed. While it is armed, every power-up pulse replays the stored copy with no help from the host. A processor that has slept can then get its bootstrap code back on wake-up. The retained memory is never reset, so its contents survive across sleeps. The copy leaves through a write port with a ready input, which lets the instruction memory stall the transfer.

Host reads return data one clock after the read strobe. Every host address must be dword aligned. The block sees a register window at offsets 0x000 to 0x010 and a retained-memory window that starts at offset 0x400.

Top module: `boot_copy_engine`

## Requirements
- R1: A host write to offset 0x400 + 4*i stores the 32-bit dword i of the retained memory. A host read at the same offset returns that dword on `hst_rdata` one clock after the read strobe. Accesses with address bits [1:0] not zero are ignored.
- R2: The source register (0x004), destination register (0x008) and count register (0x00C) store all 32 written bits and read them back unchanged. The copy uses only the low bits of each: log2(memory dwords) bits of source, IMEM_AW bits of destination and CNT_W bits of count.
- R3: Writing the control register (0x000) with bit 31 = 1 starts a copy. Control bit 31 reads 1 while the copy runs and 0 once it has finished.
- R4: For k from 0 to count-1, a copy writes retained dword (source+k) modulo the memory size to instruction address destination+k. It writes one dword on each clock where `im_ready` is high. While `im_ready` is low, `im_wr_en` stays high and `im_addr` holds.
- R5: A copy started with a count of zero issues no instruction-memory writes and sets done at once.
- R6: Status register (0x010) bit 0 is the done flag. It is 0 after reset, cleared when a copy starts, and set when the copy completes.
- R7: Host writes to the source, destination, count or control registers are ignored while a copy is running. The running copy keeps the values it started with.
- R8: Control bit 30 is the arm bit. It reads back as written. While it is 1, a one-cycle pulse on `pwrup_pulse` starts the stored copy. While it is 0, the pulse has no effect.
- R9: A `pwrup_pulse` that arrives while a copy is running is ignored. It neither restarts nor extends the copy.
- R10: After reset the control and status registers read 0 and `im_wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr_en | input | 1 | Host write strobe |
| hst_rd_en | input | 1 | Host read strobe |
| hst_addr | input | BUS_AW | Host byte address within the block |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after `hst_rd_en` |
| pwrup_pulse | input | 1 | Single-cycle power-up event |
| im_wr_en | output | 1 | Instruction-memory write request |
| im_addr | output | IMEM_AW | Instruction-memory dword address |
| im_wdata | output | 32 | Instruction-memory write data |
| im_ready | input | 1 | Instruction memory accepts the current write |

## Verification
The bench uses a 16-dword memory, so it can start a copy from every source offset with counts of 0, 1, 2, 3, 7, 16 and 19. It runs this set once with `im_ready` always high and once with a periodic stall pattern. The source sweep separates correct modulo wrap from reads that run off the end. Counts above the memory size check that the wrap repeats. A zero count separates immediate completion from a copy that issues a stray write. Stalled runs, power-up pulses with the arm bit set and cleared, and configuration writes issued during a held copy show that the engine neither restarts nor takes new values while busy.

// File: rtl/bce_pkg.sv
// Package for the bootstrap copy engine. It holds the register offsets,
// the control bit positions and the sequencer state type.
// Assumes byte addressing on the host bus with dword-aligned accesses.
package bce_pkg;
    localparam int unsigned OFS_CTRL   = 32'h000;
    localparam int unsigned OFS_SRC    = 32'h004;
    localparam int unsigned OFS_DST    = 32'h008;
    localparam int unsigned OFS_CNT    = 32'h00C;
    localparam int unsigned OFS_STAT   = 32'h010;
    localparam int unsigned OFS_MEMWIN = 32'h400;

    localparam int unsigned CTRL_GO_BIT  = 31;
    localparam int unsigned CTRL_ARM_BIT = 30;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/bce_retained_mem.sv
// Retained bootstrap memory. It has a host write port, a host read port
// whose data is registered, and an asynchronous read port for the copy
// sequencer. The array is never reset, because its contents must
// survive sleep periods.
module bce_retained_mem #(
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    input  logic [AW-1:0] cp_idx,
    output logic [31:0]   cp_data
);
    logic [31:0] store [WORDS];

    // Host write into the retained array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    // Registered host read.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= store[rd_idx];
        end
    end

    // Copy-side read, looked up in the same cycle as the address.
    always_comb begin
        cp_data = store[cp_idx];
    end
endmodule

// File: rtl/bce_regfile.sv
// Host register file. It decodes the dword-aligned host bus into the
// control, source, destination, count and status registers and the
// retained-memory window. Writes to configuration and control are
// dropped while the sequencer is busy. A valid go write while idle
// becomes a one-cycle start request.
module bce_regfile
    import bce_pkg::*;
#(
    parameter int BUS_AW    = 12,
    parameter int MEM_BYTES = 1024,
    localparam int WORDS    = MEM_BYTES / 4,
    localparam int MAW      = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wr_en,
    input  logic              hst_rd_en,
    input  logic [BUS_AW-1:0] hst_addr,
    input  logic [31:0]       hst_wdata,
    input  logic              busy,
    input  logic              done,
    output logic              go_req,
    output logic              armed,
    output logic [31:0]       src_reg,
    output logic [31:0]       dst_reg,
    output logic [31:0]       cnt_reg,
    output logic              mem_we,
    output logic              mem_re,
    output logic [MAW-1:0]    mem_idx,
    output logic              sel_mem_q,
    output logic [31:0]       reg_rdata
);
    localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
    localparam logic [BUS_AW-1:0] A_SRC  = BUS_AW'(OFS_SRC);
    localparam logic [BUS_AW-1:0] A_DST  = BUS_AW'(OFS_DST);
    localparam logic [BUS_AW-1:0] A_CNT  = BUS_AW'(OFS_CNT);
    localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(OFS_STAT);
    localparam logic [BUS_AW-1:0] A_WLO  = BUS_AW'(OFS_MEMWIN);
    localparam logic [BUS_AW:0]   A_WHI  = (BUS_AW+1)'(OFS_MEMWIN + MEM_BYTES);

    logic aligned;
    logic in_win;
    logic cfg_wr;

    // Address qualification: alignment and the memory window range.
    always_comb begin
        aligned = (hst_addr[1:0] == 2'b00);
        in_win  = aligned && (hst_addr >= A_WLO) && ({1'b0, hst_addr} < A_WHI);
        mem_we  = hst_wr_en && in_win;
        mem_re  = hst_rd_en && in_win;
        mem_idx = hst_addr[MAW+1:2];
        cfg_wr  = hst_wr_en && aligned && !busy;
        go_req  = cfg_wr && (hst_addr == A_CTRL) && hst_wdata[CTRL_GO_BIT];
    end

    // Configuration and arm registers; held while a copy runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_reg <= '0;
            dst_reg <= '0;
            cnt_reg <= '0;
            armed   <= 1'b0;
        end else if (cfg_wr) begin
            if (hst_addr == A_SRC)  src_reg <= hst_wdata;
            if (hst_addr == A_DST)  dst_reg <= hst_wdata;
            if (hst_addr == A_CNT)  cnt_reg <= hst_wdata;
            if (hst_addr == A_CTRL) armed   <= hst_wdata[CTRL_ARM_BIT];
        end
    end

    // Registered read of the register window and the select for the read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            sel_mem_q <= 1'b0;
        end else if (hst_rd_en) begin
            sel_mem_q <= in_win;
            reg_rdata <= '0;
            if (aligned) begin
                unique case (hst_addr)
                    A_CTRL: reg_rdata <= {busy, armed, 30'd0};
                    A_SRC:  reg_rdata <= src_reg;
                    A_DST:  reg_rdata <= dst_reg;
                    A_CNT:  reg_rdata <= cnt_reg;
                    A_STAT: reg_rdata <= {31'd0, done};
                    default: reg_rdata <= '0;
                endcase
            end
        end
    end

    // R7: no host write may change the configuration during a copy.
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(src_reg) && $stable(dst_reg) && $stable(cnt_reg) && $stable(armed)));
    // R3: a start request never arrives while busy.
    p_no_go_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !go_req);
endmodule

// File: rtl/bce_copy_seq.sv
// Copy sequencer. On a trigger it loads source, destination and count.
// It then moves one dword to the instruction memory on each cycle where
// the memory is ready, wrapping the source modulo the retained size.
// A zero count completes on the trigger cycle. Triggers are ignored
// while a copy is already running.
module bce_copy_seq
    import bce_pkg::*;
#(
    parameter int MAW     = 8,
    parameter int IMEM_AW = 14,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_req,
    input  logic               armed,
    input  logic               pwrup_pulse,
    input  logic [MAW-1:0]     cfg_src,
    input  logic [IMEM_AW-1:0] cfg_dst,
    input  logic [CNT_W-1:0]   cfg_cnt,
    input  logic               im_ready,
    output logic               busy,
    output logic               done,
    output logic [MAW-1:0]     rd_idx,
    output logic               im_wr_en,
    output logic [IMEM_AW-1:0] im_addr
);
    seq_state_e         state;
    logic [MAW-1:0]     src_ptr;
    logic [IMEM_AW-1:0] dst_ptr;
    logic [CNT_W-1:0]   left;
    logic               trig;

    // Trigger sources: host go, or an armed power-up event, only when idle.
    always_comb begin
        trig     = (state == SEQ_IDLE) && (go_req || (armed && pwrup_pulse));
        busy     = (state == SEQ_RUN);
        im_wr_en = busy;
        im_addr  = dst_ptr;
        rd_idx   = src_ptr;
    end

    // Copy state, pointers and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            done    <= 1'b0;
            src_ptr <= '0;
            dst_ptr <= '0;
            left    <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (trig) begin
                        src_ptr <= cfg_src;
                        dst_ptr <= cfg_dst;
                        left    <= cfg_cnt;
                        done    <= (cfg_cnt == '0);
                        if (cfg_cnt != '0) state <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (im_ready) begin
                        src_ptr <= src_ptr + 1'b1;
                        dst_ptr <= dst_ptr + 1'b1;
                        left    <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            state <= SEQ_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R4: a stalled write holds its address.
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (im_wr_en && !im_ready) |=> (im_wr_en && $stable(im_addr)));
    // R4: an accepted write is followed by the next address or by the end.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (im_wr_en && im_ready) |=> (!im_wr_en || (im_addr == IMEM_AW'($past(im_addr) + 1'b1))));
    // R6: done is clear while a started copy runs.
    p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);
    // R3: the end of a copy sets done.
    p_done_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/boot_copy_engine.sv
// Top of the bootstrap copy engine. It joins the host register file,
// the retained memory and the copy sequencer, and muxes host read data.
// Assumes MEM_BYTES is a power of two no larger than the 0x400 window.
module boot_copy_engine #(
    parameter int BUS_AW    = 12,
    parameter int MEM_BYTES = 1024,
    parameter int IMEM_AW   = 14,
    parameter int CNT_W     = 16,
    localparam int WORDS    = MEM_BYTES / 4,
    localparam int MAW      = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_wr_en,
    input  logic               hst_rd_en,
    input  logic [BUS_AW-1:0]  hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    input  logic               pwrup_pulse,
    output logic               im_wr_en,
    output logic [IMEM_AW-1:0] im_addr,
    output logic [31:0]        im_wdata,
    input  logic               im_ready
);
    logic           busy, done, go_req, armed;
    logic [31:0]    src_reg, dst_reg, cnt_reg;
    logic           mem_we, mem_re, sel_mem_q;
    logic [MAW-1:0] mem_idx, rd_idx;
    logic [31:0]    mem_rdata, reg_rdata;

    bce_regfile #(.BUS_AW(BUS_AW), .MEM_BYTES(MEM_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .busy(busy), .done(done), .go_req(go_req), .armed(armed),
        .src_reg(src_reg), .dst_reg(dst_reg), .cnt_reg(cnt_reg),
        .mem_we(mem_we), .mem_re(mem_re), .mem_idx(mem_idx),
        .sel_mem_q(sel_mem_q), .reg_rdata(reg_rdata)
    );

    bce_retained_mem #(.WORDS(WORDS)) u_mem (
        .clk(clk),
        .wr_en(mem_we), .wr_idx(mem_idx), .wr_data(hst_wdata),
        .rd_en(mem_re), .rd_idx(mem_idx), .rd_data(mem_rdata),
        .cp_idx(rd_idx), .cp_data(im_wdata)
    );

    bce_copy_seq #(.MAW(MAW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go_req(go_req), .armed(armed), .pwrup_pulse(pwrup_pulse),
        .cfg_src(src_reg[MAW-1:0]), .cfg_dst(dst_reg[IMEM_AW-1:0]),
        .cfg_cnt(cnt_reg[CNT_W-1:0]), .im_ready(im_ready),
        .busy(busy), .done(done), .rd_idx(rd_idx),
        .im_wr_en(im_wr_en), .im_addr(im_addr)
    );

    // Host read mux: memory window or register window, picked at the read strobe.
    always_comb begin
        hst_rdata = sel_mem_q ? mem_rdata : reg_rdata;
    end

    // R10: no instruction-memory write in the cycle after reset.
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> !im_wr_en);
endmodule

// File: tb/boot_copy_engine_tb_top.sv
`timescale 1ns/1ps
module boot_copy_engine_tb_top;
    localparam int BUS_AW = 12;
    localparam int MEMB   = 64;
    localparam int NW     = MEMB / 4;
    localparam int IAW    = 8;
    localparam int CW     = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hst_wr_en = 1'b0, hst_rd_en = 1'b0;
    logic [BUS_AW-1:0] hst_addr = '0;
    logic [31:0]       hst_wdata = '0, hst_rdata;
    logic              pwrup_pulse = 1'b0;
    logic              im_wr_en;
    logic [IAW-1:0]    im_addr;
    logic [31:0]       im_wdata;
    logic              im_ready = 1'b1;

    int errors = 0, checks = 0;
    int rdy_mode = 0;
    int cyc = 0;
    int nwr = 0;
    logic [31:0] model [256];

    boot_copy_engine #(.BUS_AW(BUS_AW), .MEM_BYTES(MEMB), .IMEM_AW(IAW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .pwrup_pulse(pwrup_pulse), .im_wr_en(im_wr_en), .im_addr(im_addr),
        .im_wdata(im_wdata), .im_ready(im_ready)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(int i);
        return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Ready pattern driven just after each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (rdy_mode)
            0: im_ready = 1'b1;
            1: im_ready = (cyc % 3) != 1;
            default: im_ready = 1'b0;
        endcase
    end

    // Instruction-memory model, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && im_wr_en && im_ready) begin
            model[im_addr] = im_wdata;
            nwr++;
        end
    end

    task automatic hwr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        hst_wr_en = 1'b1; hst_addr = BUS_AW'(a); hst_wdata = d;
        @(posedge clk); #1;
        hst_wr_en = 1'b0;
    endtask

    task automatic hrd(input int a, output logic [31:0] d);
        @(posedge clk); #1;
        hst_rd_en = 1'b1; hst_addr = BUS_AW'(a);
        @(posedge clk); #1;
        hst_rd_en = 1'b0;
        d = hst_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int t = 0; t < 400; t++) begin
            hrd(32'h000, v);
            if (!v[31]) break;
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 256; i++) model[i] = 32'hDEAD_BEEF;
        nwr = 0;
    endtask

    // Check the model against the expected copy of cnt dwords.
    task automatic check_copy(input int src, input int dst, input int cnt, input string req);
        logic [31:0] v;
        chk(nwr == cnt, req, 32'(nwr), 32'(cnt));
        for (int k = 0; k < cnt; k++) begin
            chk(model[(dst + k) % 256] == pat((src + k) % NW), "R4",
                model[(dst + k) % 256], pat((src + k) % NW));
        end
        hrd(32'h010, v);
        chk(v == 32'd1, "R6", v, 32'd1);
        hrd(32'h000, v);
        chk(v[31] == 1'b0, "R3", v, 32'd0);
    endtask

    task automatic run_copy(input int src, input int dst, input int cnt);
        logic [31:0] v;
        hwr(32'h004, 32'(src));
        hwr(32'h008, 32'(dst));
        hwr(32'h00C, 32'(cnt));
        clear_model();
        hwr(32'h000, 32'h8000_0000);
        if (cnt >= 4) begin
            hrd(32'h000, v);
            chk(v[31] == 1'b1, "R3", v, 32'h8000_0000);
        end
        wait_idle();
        check_copy(src, dst, cnt, cnt == 0 ? "R5" : "R4");
    endtask

    initial begin
        #200000;
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int cnts [7] = '{0, 1, 2, 3, 7, 16, 19};
        clear_model();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state.
        chk(im_wr_en == 1'b0, "R10", 32'(im_wr_en), 32'd0);
        hrd(32'h000, v); chk(v == 32'd0, "R10", v, 32'd0);
        hrd(32'h010, v); chk(v == 32'd0, "R10", v, 32'd0);

        // R1: fill and read back the retained memory.
        for (int i = 0; i < NW; i++) hwr(32'h400 + 4 * i, pat(i));
        for (int i = 0; i < NW; i++) begin
            hrd(32'h400 + 4 * i, v); chk(v == pat(i), "R1", v, pat(i));
        end
        hwr(32'h402, 32'h1234_5678);
        hrd(32'h400, v); chk(v == pat(0), "R1", v, pat(0));

        // R2: full-width readback of configuration registers.
        hwr(32'h004, 32'hFFFF_FFF3); hrd(32'h004, v); chk(v == 32'hFFFF_FFF3, "R2", v, 32'hFFFF_FFF3);
        hwr(32'h008, 32'hA5A5_0011); hrd(32'h008, v); chk(v == 32'hA5A5_0011, "R2", v, 32'hA5A5_0011);
        hwr(32'h00C, 32'h0000_0FC2); hrd(32'h00C, v); chk(v == 32'h0000_0FC2, "R2", v, 32'h0000_0FC2);
        // R2: only low bits drive the copy: src 3, dst 0x11, count 2.
        clear_model();
        hwr(32'h000, 32'h8000_0000);
        wait_idle();
        check_copy(3, 32'h11, 2, "R2");

        // R4 and R5: sweep of source and count, ready steady then stalling.
        for (int m = 0; m < 2; m++) begin
            rdy_mode = m;
            for (int s = 0; s < NW; s++)
                for (int c = 0; c < 7; c++)
                    run_copy(s, (s * 11 + c * 3) % 200, cnts[c]);
        end

        // R6 and R7: hold a copy, check done cleared, try to change the configuration.
        rdy_mode = 2;
        hwr(32'h004, 32'd2); hwr(32'h008, 32'd40); hwr(32'h00C, 32'd5);
        clear_model();
        hwr(32'h000, 32'h8000_0000);
        hrd(32'h010, v); chk(v == 32'd0, "R6", v, 32'd0);
        hwr(32'h004, 32'd9); hwr(32'h008, 32'd90); hwr(32'h00C, 32'd1);
        hwr(32'h000, 32'h4000_0000);
        hrd(32'h004, v); chk(v == 32'd2, "R7", v, 32'd2);
        hrd(32'h00C, v); chk(v == 32'd5, "R7", v, 32'd5);
        hrd(32'h000, v); chk(v == 32'h8000_0000, "R7", v, 32'h8000_0000);
        rdy_mode = 0;
        wait_idle();
        check_copy(2, 40, 5, "R7");

        // R8: arm cleared, power-up pulse has no effect.
        clear_model();
        @(posedge clk); #1 pwrup_pulse = 1'b1; @(posedge clk); #1 pwrup_pulse = 1'b0;
        repeat (20) @(posedge clk);
        chk(nwr == 0, "R8", 32'(nwr), 32'd0);
        hrd(32'h000, v); chk(v == 32'd0, "R8", v, 32'd0);

        // R8: arm set, power-up pulse replays the stored copy.
        hwr(32'h000, 32'h4000_0000);
        hrd(32'h000, v); chk(v == 32'h4000_0000, "R8", v, 32'h4000_0000);
        clear_model();
        @(posedge clk); #1 pwrup_pulse = 1'b1; @(posedge clk); #1 pwrup_pulse = 1'b0;
        wait_idle();
        check_copy(2, 40, 5, "R8");

        // R9: a pulse during a stalled armed copy is ignored.
        rdy_mode = 2;
        clear_model();
        @(posedge clk); #1 pwrup_pulse = 1'b1; @(posedge clk); #1 pwrup_pulse = 1'b0;
        repeat (3) @(posedge clk);
        #1 pwrup_pulse = 1'b1; @(posedge clk); #1 pwrup_pulse = 1'b0;
        rdy_mode = 0;
        wait_idle();
        repeat (20) @(posedge clk);
        check_copy(2, 40, 5, "R9");

        finish_run();
    end
endmodule